// File: doc/BRIEF.md
# Three-Beam Azimuth Interpolator

This block sharpens the bearing of a detection beyond the spacing of the antenna's beam positions. For one range cell it takes the return amplitudes and detection flags seen in three neighbouring beam positions (the centre position named by the request, the one just below it and the one just above it in azimuth). It takes the strongest detected beam as the coarse bearing. When a detected beam next to that one is also present, the block pulls the bearing towards it. The size of that shift comes from the normalised amplitude difference (Zi−Zj)/(Zi+Zj), passed through a small beam-shape table.

Azimuth is expressed in fine steps of 1/64 of a beam position. There are 144 beam positions per revolution, so the fine azimuth runs from 0 to 9215 and wraps around. Position 143 and position 0 are neighbours. The ratio is formed by a bit-serial restoring divider. While it works the block lowers `in_ready`, and each result leaves at a fixed delay after its request was accepted. The range cell index travels with the request so that downstream logic can pair the bearing with its cell.

Top module: `azi_interp`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A request whose three detection flags are all 0 produces no result and leaves `in_ready` at 1.
- R3: With exactly one flag set, the result is that beam's position times 64 and `out_corrected` is 0. Flag bit 0 is the lower beam (centre−1), bit 1 is the centre beam and bit 2 is the upper beam (centre+1).
- R4: The base beam is the detected beam with the largest amplitude. On equal amplitudes the centre wins over the lower beam, and the lower wins over the upper.
- R5: The companion must be detected and adjacent to the base. For a centre base it is the larger of the lower and upper beams, with the lower taken on a tie, and the shift is negative for the lower beam and positive for the upper. For a lower base it is the centre, shifted positive. For an upper base it is the centre, shifted negative. With no companion, `out_corrected` is 0 and the shift is 0.
- R6: The shift magnitude is 2·(16−q) fine steps, where q = floor(16·(Zi−Zj)/(Zi+Zj)), capped at 15. When Zi+Zj is 0, q is 15.
- R7: Beam indices and the fine azimuth wrap modulo 144 and 9216 respectively. Every output azimuth is below 9216.
- R8: A result appears exactly 17 rising edges after the edge that accepted its request. `in_ready` stays low for the 16 cycles after acceptance.
- R9: `out_range` equals the range cell of the request that produced the result.
- R10: `out_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for one range cell |
| in_ready | output | 1 | High when a request can be taken |
| in_range | input | RANGE_W | Range cell index of the request |
| in_beam | input | BEAM_W | Centre beam position, 0..BEAMS−1 |
| in_amp_lo | input | AMP_W | Amplitude in the lower beam |
| in_amp_mid | input | AMP_W | Amplitude in the centre beam |
| in_amp_hi | input | AMP_W | Amplitude in the upper beam |
| in_det | input | 3 | Detection flags {upper, centre, lower} |
| out_valid | output | 1 | Result strobe |
| out_azimuth | output | AZ_W | Fine azimuth in 1/64 beam steps |
| out_range | output | RANGE_W | Range cell of the result |
| out_corrected | output | 1 | 1 when a companion shift was applied |

## Verification
Every result is due 17 rising edges after its accepting edge. `in_ready` is due low for the 16 cycles in between. A request with no flags is due to cause no result at all. The bench notes the negedge on which it drives each request and records in a queue the negedge on which the matching result must be seen, 18 negedges later. On every negedge it compares `out_valid` and `in_ready` against that schedule, so an early, late or missing result is caught as a timing failure. The azimuth, flag and range are then checked only on the negedge where the result is due. The stimulus covers wrap at both ends of the revolution, all tie orders, a zero companion, equal amplitudes and a spread of pseudo-random cells.

// File: rtl/azi_pkg.sv
// Package: shared constants and types of the azimuth interpolator.
// Assumes: defaults describe 144 beam positions and 1/64 fine steps.
package azi_pkg;
    localparam int DEF_AMP_W   = 16;
    localparam int DEF_BEAMS   = 144;
    localparam int DEF_FRAC_W  = 6;
    localparam int DEF_LUT_AW  = 4;
    localparam int DEF_DIV_STEPS = 16;
    localparam int DEF_RANGE_W = 10;

    // Which of the three beams a selection refers to
    typedef enum logic [1:0] {
        SRC_LO  = 2'd0,
        SRC_MID = 2'd1,
        SRC_HI  = 2'd2
    } beam_src_e;
endpackage

// File: rtl/azi_select.sv
// Module: picks the base beam and the companion beam of one range cell,
// and forms the difference and sum of their amplitudes for the divider.
// Assumes: in_beam < BEAMS; purely combinational.
module azi_select
    import azi_pkg::*;
#(
    parameter int AMP_W  = DEF_AMP_W,
    parameter int BEAMS  = DEF_BEAMS,
    parameter int BEAM_W = $clog2(BEAMS)
) (
    input  logic [BEAM_W-1:0] in_beam,
    input  logic [AMP_W-1:0]  amp_lo,
    input  logic [AMP_W-1:0]  amp_mid,
    input  logic [AMP_W-1:0]  amp_hi,
    input  logic [2:0]        det,
    output logic              any_det,
    output logic [BEAM_W-1:0] base_beam,
    output logic              has_comp,
    output logic              comp_neg,
    output logic [AMP_W-1:0]  amp_diff,
    output logic [AMP_W:0]    amp_sum
);
    localparam logic [BEAM_W-1:0] LAST = BEAM_W'(BEAMS - 1);

    logic [BEAM_W-1:0] lo_idx, hi_idx;
    beam_src_e         best_src;
    logic [AMP_W-1:0]  best_amp, comp_amp;

    // Neighbour positions with wrap around the revolution
    always_comb begin
        lo_idx = (in_beam == '0)   ? LAST : in_beam - BEAM_W'(1);
        hi_idx = (in_beam == LAST) ? '0   : in_beam + BEAM_W'(1);
    end

    // Strongest detected beam, priority centre, lower, upper on ties
    always_comb begin
        best_src = SRC_MID;
        best_amp = amp_mid;
        if (det[0] && (!det[1] || amp_lo > best_amp)) begin
            best_src = SRC_LO;
            best_amp = amp_lo;
        end
        if (det[2] && (!(det[1] || det[0]) || amp_hi > best_amp)) begin
            best_src = SRC_HI;
            best_amp = amp_hi;
        end
    end

    // Companion beam adjacent to the base, with direction of the shift
    always_comb begin
        has_comp = 1'b0;
        comp_neg = 1'b0;
        comp_amp = '0;
        unique case (best_src)
            SRC_MID: begin
                if (det[0] && det[2]) begin
                    has_comp = 1'b1;
                    comp_neg = !(amp_hi > amp_lo);
                    comp_amp = (amp_hi > amp_lo) ? amp_hi : amp_lo;
                end else if (det[0]) begin
                    has_comp = 1'b1;
                    comp_neg = 1'b1;
                    comp_amp = amp_lo;
                end else if (det[2]) begin
                    has_comp = 1'b1;
                    comp_amp = amp_hi;
                end
            end
            SRC_LO: begin
                has_comp = det[1];
                comp_amp = det[1] ? amp_mid : '0;
            end
            SRC_HI: begin
                has_comp = det[1];
                comp_neg = det[1];
                comp_amp = det[1] ? amp_mid : '0;
            end
            default: ;
        endcase
    end

    // Base position and divider operands
    always_comb begin
        any_det = |det;
        unique case (best_src)
            SRC_LO:  base_beam = lo_idx;
            SRC_HI:  base_beam = hi_idx;
            default: base_beam = in_beam;
        endcase
        amp_diff = best_amp - comp_amp;
        amp_sum  = {1'b0, best_amp} + {1'b0, comp_amp};
    end
endmodule

// File: rtl/azi_divider.sv
// Module: bit-serial restoring divider producing STEPS fraction bits of
// num/den, one bit per clock; done pulses on the cycle busy falls.
// Assumes: start only while idle; num <= den gives a fraction below one,
// num == den or den == 0 saturates to all ones.
module azi_divider #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 17,
    parameter int STEPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [STEPS-1:0] quo
);
    localparam int REM_W = DEN_W + 2;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [REM_W-1:0] rem, shifted, step_rem;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt;
    logic             step_bit;

    // One trial subtraction of the doubled remainder
    always_comb begin
        shifted  = {rem[REM_W-2:0], 1'b0};
        step_bit = shifted >= REM_W'(den_q);
        step_rem = step_bit ? shifted - REM_W'(den_q) : shifted;
    end

    // Iteration state: load on start, shift one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= CNT_W'(STEPS);
                rem   <= REM_W'(num);
                den_q <= den;
                quo   <= '0;
            end else if (busy) begin
                rem <= step_rem;
                quo <= {quo[STEPS-2:0], step_bit};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R8
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/azi_shape_lut.sv
// Module: beam-shape table mapping the quantised amplitude ratio to a
// shift magnitude in fine steps; entries are computed, half a beam at q=0.
// Assumes: FRAC_W bits hold half a beam step (2**(FRAC_W-1)).
module azi_shape_lut #(
    parameter int LUT_AW = 4,
    parameter int FRAC_W = 6
) (
    input  logic [LUT_AW-1:0] idx,
    output logic [FRAC_W-1:0] shift
);
    localparam int ENTRIES = 1 << LUT_AW;
    localparam int HALF    = 1 << (FRAC_W - 1);

    logic [FRAC_W-1:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam int VAL = ((ENTRIES - g) * HALF) / ENTRIES;
        assign table_q[g] = FRAC_W'(VAL);
    end

    assign shift = table_q[idx];
endmodule

// File: rtl/azi_interp.sv
// Module: top of the three-beam azimuth interpolator. Accepts one range
// cell when idle, runs the ratio division, then emits the fine azimuth.
// Assumes: in_beam < BEAMS; a request with no flags is discarded.
module azi_interp
    import azi_pkg::*;
#(
    parameter int AMP_W     = DEF_AMP_W,
    parameter int BEAMS     = DEF_BEAMS,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int LUT_AW    = DEF_LUT_AW,
    parameter int DIV_STEPS = DEF_DIV_STEPS,
    parameter int RANGE_W   = DEF_RANGE_W,
    parameter int BEAM_W    = $clog2(BEAMS),
    parameter int AZ_W      = $clog2(BEAMS << FRAC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [RANGE_W-1:0] in_range,
    input  logic [BEAM_W-1:0]  in_beam,
    input  logic [AMP_W-1:0]   in_amp_lo,
    input  logic [AMP_W-1:0]   in_amp_mid,
    input  logic [AMP_W-1:0]   in_amp_hi,
    input  logic [2:0]         in_det,
    output logic               out_valid,
    output logic [AZ_W-1:0]    out_azimuth,
    output logic [RANGE_W-1:0] out_range,
    output logic               out_corrected
);
    localparam int AZ_MOD = BEAMS << FRAC_W;
    localparam int EXT_W  = AZ_W + 1;

    logic              any_det, has_comp, comp_neg, accept;
    logic [BEAM_W-1:0] base_beam;
    logic [AMP_W-1:0]  amp_diff;
    logic [AMP_W:0]    amp_sum;
    logic              div_busy, div_done;
    logic [DIV_STEPS-1:0] quo;
    logic [FRAC_W-1:0] shift_mag;

    logic [BEAM_W-1:0]  ctx_base;
    logic               ctx_comp, ctx_neg;
    logic [RANGE_W-1:0] ctx_range;
    logic [EXT_W-1:0]   base_fine, shift_ext, up_sum, az_next;

    azi_select #(.AMP_W(AMP_W), .BEAMS(BEAMS), .BEAM_W(BEAM_W)) u_select (
        .in_beam  (in_beam),
        .amp_lo   (in_amp_lo),
        .amp_mid  (in_amp_mid),
        .amp_hi   (in_amp_hi),
        .det      (in_det),
        .any_det  (any_det),
        .base_beam(base_beam),
        .has_comp (has_comp),
        .comp_neg (comp_neg),
        .amp_diff (amp_diff),
        .amp_sum  (amp_sum)
    );

    azi_divider #(.NUM_W(AMP_W), .DEN_W(AMP_W + 1), .STEPS(DIV_STEPS)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .num  (amp_diff),
        .den  (amp_sum),
        .busy (div_busy),
        .done (div_done),
        .quo  (quo)
    );

    azi_shape_lut #(.LUT_AW(LUT_AW), .FRAC_W(FRAC_W)) u_lut (
        .idx  (quo[DIV_STEPS-1 -: LUT_AW]),
        .shift(shift_mag)
    );

    assign in_ready = !div_busy;
    assign accept   = in_valid && in_ready && any_det;

    // Capture the selection context of the accepted cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_base  <= '0;
            ctx_comp  <= 1'b0;
            ctx_neg   <= 1'b0;
            ctx_range <= '0;
        end else if (accept) begin
            ctx_base  <= base_beam;
            ctx_comp  <= has_comp;
            ctx_neg   <= comp_neg;
            ctx_range <= in_range;
        end
    end

    // Apply the signed shift to the base position, wrapping the revolution
    always_comb begin
        base_fine = EXT_W'(ctx_base) << FRAC_W;
        shift_ext = EXT_W'(shift_mag);
        up_sum    = base_fine + shift_ext;
        if (!ctx_comp) begin
            az_next = base_fine;
        end else if (ctx_neg) begin
            az_next = (base_fine >= shift_ext) ? base_fine - shift_ext
                                               : base_fine + EXT_W'(AZ_MOD) - shift_ext;
        end else begin
            az_next = (up_sum >= EXT_W'(AZ_MOD)) ? up_sum - EXT_W'(AZ_MOD) : up_sum;
        end
    end

    // Output register, loaded once when the division completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_azimuth   <= '0;
            out_range     <= '0;
            out_corrected <= 1'b0;
        end else begin
            out_valid <= div_done;
            if (div_done) begin
                out_azimuth   <= AZ_W'(az_next);
                out_range     <= ctx_range;
                out_corrected <= ctx_comp;
            end
        end
    end

    // R8
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R7
    az_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_azimuth < AZ_W'(AZ_MOD));
    // R3
    plain_beam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_corrected) |-> out_azimuth[FRAC_W-1:0] == '0);
    // R6
    shifted_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corrected) |-> out_azimuth[FRAC_W-1:0] != '0);
endmodule

// File: tb/azi_interp_test.sv
module azi_interp_test;
    localparam int RW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [RW-1:0] in_range = '0;
    logic [7:0]  in_beam = '0;
    logic [15:0] in_amp_lo = '0, in_amp_mid = '0, in_amp_hi = '0;
    logic [2:0]  in_det = '0;
    logic        out_valid;
    logic [13:0] out_azimuth;
    logic [RW-1:0] out_range;
    logic        out_corrected;

    int checks = 0;
    int fails = 0;
    int ncyc = 0;
    int busy_until = -1;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    int q_due[$], q_az[$], q_rng[$], q_corr[$];
    string q_tag[$];
    int unsigned lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    azi_interp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_range(in_range), .in_beam(in_beam), .in_amp_lo(in_amp_lo),
        .in_amp_mid(in_amp_mid), .in_amp_hi(in_amp_hi), .in_det(in_det),
        .out_valid(out_valid), .out_azimuth(out_azimuth), .out_range(out_range),
        .out_corrected(out_corrected)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, ncyc, act, exp);
        end
    endtask

    // Behavioural model of one request: returns azimuth and shift flag
    function automatic void model(input int c, input int zl, input int zm, input int zh,
                                  input int det, output int az, output int corr);
        int lo, hi, bsrc, bamp, csrc, camp, base, q, off, sgn;
        lo = (c + 143) % 144;
        hi = (c + 1) % 144;
        bsrc = -1; bamp = -1;
        if (det[1]) begin bsrc = 1; bamp = zm; end
        if (det[0] && zl > bamp) begin bsrc = 0; bamp = zl; end
        if (det[2] && zh > bamp) begin bsrc = 2; bamp = zh; end
        csrc = -1; camp = 0; sgn = 0;
        if (bsrc == 1) begin
            if (det[0] && det[2]) begin
                if (zh > zl) begin csrc = 2; camp = zh; sgn = 1; end
                else begin csrc = 0; camp = zl; sgn = -1; end
            end else if (det[0]) begin csrc = 0; camp = zl; sgn = -1; end
            else if (det[2]) begin csrc = 2; camp = zh; sgn = 1; end
        end else if (bsrc == 0 && det[1]) begin csrc = 1; camp = zm; sgn = 1; end
        else if (bsrc == 2 && det[1]) begin csrc = 1; camp = zm; sgn = -1; end
        base = (bsrc == 0) ? lo : (bsrc == 2) ? hi : c;
        if (csrc < 0) begin
            az = base * 64; corr = 0;
        end else begin
            if (bamp + camp == 0) q = 15;
            else q = (16 * (bamp - camp)) / (bamp + camp);
            if (q > 15) q = 15;
            off = 2 * (16 - q);
            az = (base * 64 + sgn * off + 9216) % 9216;
            corr = 1;
        end
    endfunction

    task automatic send(input string tag, input int rng, input int c, input int zl,
                        input int zm, input int zh, input int det);
        int az, corr, k;
        do begin
            @(negedge clk); #1;
        end while (!in_ready);
        k = ncyc;
        in_valid = 1'b1; in_range = RW'(rng); in_beam = 8'(c);
        in_amp_lo = 16'(zl); in_amp_mid = 16'(zm); in_amp_hi = 16'(zh); in_det = 3'(det);
        if (det != 0) begin
            model(c, zl, zm, zh, det, az, corr);
            q_due.push_back(k + 18); q_az.push_back(az); q_rng.push_back(rng);
            q_corr.push_back(corr); q_tag.push_back(tag);
            busy_until = k + 16;
        end
        @(negedge clk); #1;
        in_valid = 1'b0;
        if (det == 0) chk(in_ready == 1'b1, "R2 ready after empty cell", int'(in_ready), 1);
    endtask

    // Per-cycle comparison of timing and results against the model
    always @(negedge clk) begin
        bit due;
        ncyc++;
        if (mon_en && rst_n) begin
            chk(in_ready == (ncyc > busy_until), "R8 in_ready", int'(in_ready),
                int'(ncyc > busy_until));
            due = (q_due.size() > 0) && (q_due[0] == ncyc);
            chk(out_valid == due, "R8/R10 out_valid timing", int'(out_valid), int'(due));
            if (due) begin
                chk(int'(out_azimuth) == q_az[0], q_tag[0], int'(out_azimuth), q_az[0]);
                chk(int'(out_corrected) == q_corr[0], {q_tag[0], " shift flag"},
                    int'(out_corrected), q_corr[0]);
                chk(int'(out_range) == q_rng[0], "R9 range", int'(out_range), q_rng[0]);
                void'(q_due.pop_front()); void'(q_az.pop_front()); void'(q_rng.pop_front());
                void'(q_corr.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        mon_en = 1'b1;
        // R2 empty cell discarded
        send("R2 empty", 1, 20, 500, 900, 300, 0);
        // R3 single detections, including wrap of neighbours (R7)
        send("R3 centre only", 2, 10, 0, 800, 0, 3'b010);
        send("R3 R7 lower only at 0", 3, 0, 700, 0, 0, 3'b001);
        send("R3 R7 upper only at 143", 4, 143, 0, 0, 700, 3'b100);
        // R5 R6 centre base with one companion
        send("R6 centre+upper", 5, 50, 0, 1000, 600, 3'b110);
        send("R5 centre+lower", 6, 50, 600, 1000, 0, 3'b011);
        send("R5 three, upper larger", 7, 70, 200, 1000, 900, 3'b111);
        // R4 ties
        send("R4 tie centre vs lower", 8, 30, 800, 800, 100, 3'b111);
        send("R4 R5 tie lower vs upper", 9, 30, 400, 900, 400, 3'b111);
        send("R4 tie lower vs upper, no centre", 10, 30, 500, 0, 500, 3'b101);
        // R5 side bases
        send("R5 lower base, centre companion", 11, 60, 900, 700, 0, 3'b011);
        send("R5 upper base, centre companion", 12, 60, 0, 700, 900, 3'b110);
        send("R5 upper base, no adjacent", 13, 60, 300, 0, 900, 3'b101);
        // R6 extremes
        send("R6 zero companion", 14, 80, 0, 600, 0, 3'b110);
        send("R6 equal amplitudes", 15, 80, 0, 500, 500, 3'b110);
        send("R6 both zero", 16, 80, 0, 0, 0, 3'b110);
        // R7 wrap of the fine azimuth
        send("R7 wrap below zero", 17, 0, 600, 1000, 0, 3'b011);
        send("R7 upper base 0, shift down", 18, 143, 0, 700, 900, 3'b110);
        send("R7 lower base 143, shift up", 19, 0, 900, 700, 0, 3'b011);
        // Pseudo-random cells (R4 R5 R6 R9)
        for (int n = 0; n < 40; n++) begin
            int c, zl, zm, zh, d;
            lcg = lcg * 1103515245 + 12345; c = int'((lcg >> 8) % 144);
            lcg = lcg * 1103515245 + 12345; zl = int'((lcg >> 8) % 4096);
            lcg = lcg * 1103515245 + 12345; zm = int'((lcg >> 8) % 4096);
            lcg = lcg * 1103515245 + 12345; zh = int'((lcg >> 8) % 4096);
            lcg = lcg * 1103515245 + 12345; d = int'((lcg >> 8) % 8);
            send("R4 R5 R6 random", 100 + n, c, zl, zm, zh, d);
        end
        repeat (30) @(negedge clk);
        #1;
        chk(q_due.size() == 0, "R8 all results delivered", q_due.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL R8 watchdog expired: actual %0d expected %0d", ncyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule